// File: doc/BRIEF.md
# Masked Block-Write Pixel Memory Write Unit

This block is the write side of a graphics frame-buffer store. It holds an array of 16-bit words whose depth is set by a parameter. The full-size array has 262144 words; simulation uses a much smaller one. One command is accepted on every clock.

A command can do one of four things:
- write a single word;
- fill any subset of an aligned group of four neighbouring columns from an internal color register;
- reload the color register;
- reload the per-bit write mask.

Two byte enables qualify every write and every register load. Writing commands come in a plain form and in a masked form. Only the masked forms are gated by the write mask. The mask keeps its value until it is loaded again.

The array is split into four column banks, so one cycle can update all four words of a group. That is up to 64 bits written per cycle. A read returns the stored word on the clock after the read command, and the read result stays on the output until the next read.

Top module: `pixwr_unit`

## Requirements
- R1: Reset sets the read output to 0, the color register to 0 and the write mask to all ones. A masked write issued right after reset therefore stores every enabled bit.
- R2: Command code 1 (read) places the word at `addr` on `rd_data` at the clock edge that samples it. The mask is not applied. `rd_data` keeps that value through every later non-read command.
- R3: Command code 7 (load color) copies `din` into the color register, only in the bytes whose byte enable is 1.
- R4: Command code 6 (load mask) copies `din` into the write mask, only in the bytes whose byte enable is 1. The other mask bytes keep their value.
- R5: Command code 2 (plain write) stores `din` at `addr` in the enabled bytes and ignores the write mask.
- R6: Command code 3 (masked write) changes a bit of the word at `addr` only when its byte is enabled and its mask bit is 1. Every other bit keeps its old value.
- R7: The mask persists. No-operation (code 0) and all commands other than code 6 leave it unchanged, and later masked writes keep using it.
- R8: Command code 4 (block write) ignores `addr[1:0]`. It writes the color register to column group base + j for each j in 0..3 with `din[j]` = 1, where bit 0 selects the lowest column. Enabled bytes are written and the mask is ignored. Unselected columns keep their data.
- R9: Command code 5 (masked block write) behaves like code 4, but each selected column word is also gated bit by bit by the write mask.
- R10: `byte_en[0]` gates bits 7:0 and `byte_en[1]` gates bits 15:8. A write or load with `byte_en` = 0 changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code (0 nop, 1 read, 2 write, 3 masked write, 4 block write, 5 masked block write, 6 load mask, 7 load color) |
| addr | input | ADDR_W (10) | Word address; the low two bits pick the column in a group |
| din | input | DATA_W (16) | Write data, register load value, or column selects in bits 3:0 for block writes |
| byte_en | input | DATA_W/8 (2) | Byte enables for writes and register loads |
| rd_data | output | DATA_W (16) | Word returned by the most recent read |

## Verification
Every word is first filled with a distinct address-derived pattern. Because each word differs, a wrong bank, a wrong column offset or a lost aligned base shows up as a mismatched read.

The mask and color registers are then loaded with half-byte-enable values. Masked and plain variants of word and block writes are issued against those values. This separates commands that must honour the mask from those that must not, and it separates byte lane 0 from lane 1.

Block-write column selects of 0101, 1111 and 0000, issued at unaligned addresses, show whether the low address bits are dropped and which select bit maps to which column. Runs of no-operations and zero-byte-enable commands between loads confirm that the mask persists and that disabled stores are discarded.

// File: rtl/pixwr_pkg.sv
package pixwr_pkg;

   typedef enum logic [2:0] {
      PW_NOP      = 3'd0,
      PW_READ     = 3'd1,
      PW_WRITE    = 3'd2,
      PW_WRITE_M  = 3'd3,
      PW_BLOCK    = 3'd4,
      PW_BLOCK_M  = 3'd5,
      PW_LD_MASK  = 3'd6,
      PW_LD_COLOR = 3'd7
   } pw_cmd_e;

   typedef struct packed {
      logic rd;
      logic word_wr;
      logic blk_wr;
      logic use_mask;
      logic ld_mask;
      logic ld_color;
   } pw_dec_t;

   function automatic pw_dec_t pw_decode(input pw_cmd_e c);
      pw_dec_t d;
      d          = '0;
      d.rd       = (c == PW_READ);
      d.word_wr  = (c == PW_WRITE) || (c == PW_WRITE_M);
      d.blk_wr   = (c == PW_BLOCK) || (c == PW_BLOCK_M);
      d.use_mask = (c == PW_WRITE_M) || (c == PW_BLOCK_M);
      d.ld_mask  = (c == PW_LD_MASK);
      d.ld_color = (c == PW_LD_COLOR);
      return d;
   endfunction

endpackage

// File: rtl/pixwr_regs.sv
module pixwr_regs #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_mask,
   input  logic              ld_color,
   input  logic [DATA_W-1:0] lane_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] color_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '1;
         color_q <= '0;
      end else begin
         if (ld_mask)
            mask_q <= (mask_q & ~lane_en) | (din & lane_en);
         if (ld_color)
            color_q <= (color_q & ~lane_en) | (din & lane_en);
      end
   end

endmodule

// File: rtl/pixwr_lane_gen.sv
module pixwr_lane_gen #(
   parameter int DATA_W  = 16,
   parameter int COLS    = 4,
   parameter int COL_LSB = 2
) (
   input  logic               word_wr,
   input  logic               blk_wr,
   input  logic               use_mask,
   input  logic [COL_LSB-1:0] col,
   input  logic [COLS-1:0]    col_sel,
   input  logic [DATA_W-1:0]  lane_en,
   input  logic [DATA_W-1:0]  mask_q,
   output logic [COLS-1:0]    bank_we,
   output logic [DATA_W-1:0]  bit_en
);

   always_comb begin
      bit_en = use_mask ? (lane_en & mask_q) : lane_en;
   end

   for (genvar j = 0; j < COLS; j++) begin : g_col
      always_comb begin
         bank_we[j] = (word_wr && (col == COL_LSB'(j))) || (blk_wr && col_sel[j]);
      end
   end

endmodule

// File: rtl/pixwr_bank.sv
module pixwr_bank #(
   parameter int DATA_W = 16,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     row,
   input  logic [DATA_W-1:0] bit_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[row] <= (mem[row] & ~bit_en) | (wdata & bit_en);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (re)
         rdata <= mem[row];
   end

endmodule

// File: rtl/pixwr_unit.sv
module pixwr_unit
   import pixwr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 10,
   parameter int BLK_COLS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          cmd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   din,
   input  logic [DATA_W/8-1:0] byte_en,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int NBYTES  = DATA_W / 8;
   localparam int COL_LSB = $clog2(BLK_COLS);
   localparam int BANK_AW = ADDR_W - COL_LSB;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("pixwr_unit: DATA_W must be a multiple of 8");
   end
   if ((1 << COL_LSB) != BLK_COLS || BLK_COLS < 2) begin : g_bad_cols
      $error("pixwr_unit: BLK_COLS must be a power of two of at least 2");
   end
   if (BLK_COLS > DATA_W || BANK_AW < 1) begin : g_bad_geom
      $error("pixwr_unit: column group does not fit data or address width");
   end

   pw_dec_t           dec;
   logic [DATA_W-1:0] lane_en;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] color_q;
   logic [DATA_W-1:0] bit_en;
   logic [DATA_W-1:0] wdata;
   logic [BLK_COLS-1:0] bank_we;
   logic [DATA_W-1:0] bank_rd [BLK_COLS];
   logic [COL_LSB-1:0] col;
   logic [BANK_AW-1:0] row;
   logic [COL_LSB-1:0] rd_sel_q;

   always_comb begin
      dec = pw_decode(pw_cmd_e'(cmd));
      col = addr[COL_LSB-1:0];
      row = addr[ADDR_W-1:COL_LSB];
      wdata = dec.blk_wr ? color_q : din;
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      always_comb begin
         lane_en[8*b +: 8] = {8{byte_en[b]}};
      end
   end

   pixwr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_mask  (dec.ld_mask),
      .ld_color (dec.ld_color),
      .lane_en  (lane_en),
      .din      (din),
      .mask_q   (mask_q),
      .color_q  (color_q)
   );

   pixwr_lane_gen #(
      .DATA_W  (DATA_W),
      .COLS    (BLK_COLS),
      .COL_LSB (COL_LSB)
   ) u_lane (
      .word_wr  (dec.word_wr),
      .blk_wr   (dec.blk_wr),
      .use_mask (dec.use_mask),
      .col      (col),
      .col_sel  (din[BLK_COLS-1:0]),
      .lane_en  (lane_en),
      .mask_q   (mask_q),
      .bank_we  (bank_we),
      .bit_en   (bit_en)
   );

   for (genvar j = 0; j < BLK_COLS; j++) begin : g_bank
      logic re_j;
      always_comb re_j = dec.rd && (col == COL_LSB'(j));
      pixwr_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (bank_we[j]),
         .re     (re_j),
         .row    (row),
         .bit_en (bit_en),
         .wdata  (wdata),
         .rdata  (bank_rd[j])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_sel_q <= '0;
      else if (dec.rd)
         rd_sel_q <= col;
   end

   always_comb rd_data = bank_rd[rd_sel_q];

endmodule

// File: rtl/pixwr_unit_chk.sv
module pixwr_unit_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2:0]          cmd,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   din,
   input logic [DATA_W/8-1:0] byte_en,
   input logic [DATA_W-1:0]   rd_data,
   input logic [DATA_W-1:0]   mask_q,
   input logic [DATA_W-1:0]   color_q
);

   // R1: the cycle after reset the mask is all ones and color is cleared
   a_r1_reset_regs: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '1) && (color_q == '0));

   // R2: read output holds across non-read commands
   a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 3'd1) |=> $stable(rd_data));

   // R3: full-width color load takes din
   a_r3_color_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd7 && byte_en == '1) |=> (color_q == $past(din)));

   // R4: full-width mask load takes din
   a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd6 && byte_en == '1) |=> (mask_q == $past(din)));

   // R7: mask persists through every other command
   a_r7_mask_persist: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 3'd6) |=> $stable(mask_q));

   // R10: loads with no byte enabled change nothing
   a_r10_no_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 3'd6 || cmd == 3'd7) && byte_en == '0) |=>
         ($stable(mask_q) && $stable(color_q)));

endmodule

bind pixwr_unit pixwr_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd     (cmd),
   .addr    (addr),
   .din     (din),
   .byte_en (byte_en),
   .rd_data (rd_data),
   .mask_q  (mask_q),
   .color_q (color_q)
);

// File: tb/pixwr_unit_bench.sv
`timescale 1ns/100ps
module pixwr_unit_bench;

   localparam int DW    = 16;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd = 3'd0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [1:0]    byte_en = 2'b00;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   pixwr_unit u_pixwr_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .addr    (addr),
      .din     (din),
      .byte_en (byte_en),
      .rd_data (rd_data)
   );

   // behavioural reference model
   logic [DW-1:0] m_mem [DEPTH];
   logic [DW-1:0] m_mask, m_color, m_rd;

   function automatic logic [DW-1:0] ben16(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   always @(posedge clk) begin
      logic [DW-1:0] en;
      int base;
      if (!rst_n) begin
         m_mask = 16'hFFFF; m_color = 16'h0000; m_rd = 16'h0000;
      end else begin
         en = ben16(byte_en);
         case (cmd)
            3'd1: m_rd = m_mem[addr];
            3'd2: m_mem[addr] = (m_mem[addr] & ~en) | (din & en);
            3'd3: m_mem[addr] = (m_mem[addr] & ~(en & m_mask)) | (din & en & m_mask);
            3'd4, 3'd5: begin
               if (cmd == 3'd5) en = en & m_mask;
               base = int'(addr) & ~3;
               for (int j = 0; j < 4; j++)
                  if (din[j])
                     m_mem[base + j] = (m_mem[base + j] & ~en) | (m_color & en);
            end
            3'd6: m_mask = (m_mask & ~en) | (din & en);
            3'd7: m_color = (m_color & ~en) | (din & en);
            default: ;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (rd_data !== m_rd) begin
            failures++;
            $display("FAIL %s per-cycle rd_data actual=%h expected=%h", cur_req, rd_data, m_rd);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [DW-1:0] init_val(input int i);
      return 16'(i * 37) ^ 16'hA5A5;
   endfunction

   task automatic step(input logic [2:0] c, input int a, input logic [DW-1:0] d,
                       input logic [1:0] be);
      cmd = c; addr = AW'(a); din = d; byte_en = be;
      @(posedge clk);
      @(negedge clk);
      cmd = 3'd0;
   endtask

   task automatic read_chk(input int a, input logic [DW-1:0] exp, input string req);
      step(3'd1, a, 16'h0, 2'b00);
      checks++;
      if (rd_data !== exp) begin
         failures++;
         $display("FAIL %s read @%0h actual=%h expected=%h", req, a, rd_data, exp);
      end
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      checks++;
      if (rd_data !== 16'h0) begin
         failures++;
         $display("FAIL R1 reset rd_data actual=%h expected=0000", rd_data);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R5: fill with distinct patterns
      cur_req = "R5";
      for (int i = 0; i < DEPTH; i++) step(3'd2, i, init_val(i), 2'b11);
      cur_req = "R2";
      read_chk(0, init_val(0), "R2");
      read_chk(3, init_val(3), "R2");
      read_chk(1023, init_val(1023), "R2");
      repeat (3) step(3'd0, 0, 16'hFFFF, 2'b11);
      read_chk(514, init_val(514), "R2");

      // R1: mask is all ones after reset
      cur_req = "R1";
      step(3'd3, 5, 16'h1234, 2'b11);
      read_chk(5, 16'h1234, "R1");

      // R4: half-byte mask load -> 0xFFF0
      cur_req = "R4";
      step(3'd6, 0, 16'h00F0, 2'b01);
      step(3'd3, 8, 16'h0000, 2'b11);
      read_chk(8, init_val(8) & 16'h000F, "R4");

      // R6: masked write with lane 1 only
      cur_req = "R6";
      step(3'd3, 12, 16'h0000, 2'b10);
      read_chk(12, init_val(12) & 16'h00FF, "R6");

      // R5 / R10: plain write ignores mask, upper lane only
      cur_req = "R5";
      step(3'd2, 9, 16'hBEEF, 2'b10);
      read_chk(9, {8'hBE, init_val(9)[7:0]}, "R5");
      step(3'd2, 10, 16'h0001, 2'b01);
      read_chk(10, {init_val(10)[15:8], 8'h01}, "R10");

      // R3: color loads
      cur_req = "R3";
      step(3'd7, 0, 16'h5A3C, 2'b11);
      step(3'd7, 0, 16'h0077, 2'b01);
      step(3'd4, 16'h30, 16'h0001, 2'b11);
      read_chk(16'h30, 16'h5A77, "R3");

      // R8: block write, unaligned address, selects 0101, mask ignored
      cur_req = "R8";
      step(3'd4, 16'h13, 16'h0005, 2'b11);
      read_chk(16'h10, 16'h5A77, "R8");
      read_chk(16'h11, init_val(16'h11), "R8");
      read_chk(16'h12, 16'h5A77, "R8");
      read_chk(16'h13, init_val(16'h13), "R8");
      step(3'd4, 16'h41, 16'h0000, 2'b11);
      read_chk(16'h40, init_val(16'h40), "R8");

      // R9: masked block write, mask -> 0x0FF0
      cur_req = "R9";
      step(3'd6, 0, 16'h0F00, 2'b10);
      step(3'd5, 16'h22, 16'h000F, 2'b11);
      for (int j = 0; j < 4; j++)
         read_chk(16'h20 + j, (init_val(16'h20 + j) & 16'hF00F) | (16'h5A77 & 16'h0FF0), "R9");
      step(3'd5, 16'h26, 16'h0002, 2'b01);
      read_chk(16'h25, (init_val(16'h25) & 16'hFF0F) | 16'h0070, "R9");

      // R7: mask persists across many commands
      cur_req = "R7";
      repeat (20) step(3'd0, 0, 16'hFFFF, 2'b11);
      step(3'd7, 0, 16'hFFFF, 2'b11);
      step(3'd3, 16'h50, 16'hFFFF, 2'b11);
      read_chk(16'h50, init_val(16'h50) | 16'h0FF0, "R7");

      // R10: zero byte enables store nothing
      cur_req = "R10";
      step(3'd2, 16'h60, 16'h0000, 2'b00);
      step(3'd4, 16'h60, 16'h000F, 2'b00);
      step(3'd6, 0, 16'h0000, 2'b00);
      read_chk(16'h60, init_val(16'h60), "R10");
      step(3'd3, 16'h61, 16'h0000, 2'b11);
      read_chk(16'h61, init_val(16'h61) & 16'hF00F, "R10");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule